// File: doc/BRIEF.md
# Controller Base and Mode Register Guard

This block owns the base/mode register of a single local interrupt controller and screens every software write to it. The controller is always in one of three modes: off (enable clear), legacy (enable set, extended clear) or extended (both set). A write request carries a 64-bit value; the guard compares the requested mode with the current one and either commits the value or refuses it and pulses an error output for one cycle. Alongside the mode it keeps the 20-bit base address field and a boot-processor flag that software cannot change.

When the controller moves into extended mode, the guard derives a 32-bit logical ID from a fixed per-controller initial ID input. It also holds the software-visible 8-bit legacy ID. That ID may be rewritten outside extended mode, and any write to the base register restores it to the initial ID. When a write turns the controller off, a one-cycle strobe tells the neighbouring logic to clear the software-enable bit of its spurious vector register. A capability input states whether extended mode exists at all.

Top module: `cmg_mode_guard`

## Requirements
- R1: After reset the mode is legacy. `base_q` equals the reset base in bits 31:12, with enable (bit 11) = 1, extended (bit 10) = 0, boot flag (bit 8) = RST_BSP and all other bits 0. `legacy_id` equals `init_id[7:0]`, `ext_logical_id` is 0, and `wr_err` and `sv_enable_clr` are low.
- R2: A write whose extended bit (bit 10) is set is rejected when `ext_supported` is low.
- R3: A write with extended = 1 and enable (bit 11) = 0 is rejected.
- R4: A write that asks for extended mode while the controller is off is rejected. Off must pass through legacy first.
- R5: A write with enable = 1 and extended = 0 while the controller is in extended mode is rejected.
- R6: A rejected write leaves `base_q` and `mode_o` unchanged. `wr_err` is high for exactly the one cycle after the request cycle.
- R7: An accepted write loads `wr_val[31:12]` into the base field, and `base_q` shows it in the cycle after the request. The boot flag keeps its previous value. All other value bits are ignored.
- R8: An accepted write with enable = 0 puts the controller in off mode (mode code 0, enable and extended both 0) and raises `sv_enable_clr` for one cycle. A later accepted write with enable = 1 and extended = 0 returns it to legacy (mode code 1).
- R9: An accepted write that enters extended mode (mode code 2) from legacy loads `ext_logical_id`. Its upper 16 bits are `init_id >> 4`. Its lower 16 bits are one-hot at bit `init_id[3:0]`.
- R10: Every base write request, accepted or rejected, restores `legacy_id` to `init_id[7:0]` in the following cycle.
- R11: A legacy ID write (`id_wr`) loads `id_wr_val` into `legacy_id` unless the mode is extended, in which case it is ignored. If a base write is requested in the same cycle, the base write's restore wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| init_id | input | ID_W | Fixed initial identifier of this controller |
| ext_supported | input | 1 | Extended mode is available |
| wr_req | input | 1 | Base register write request, one write per cycle high |
| wr_val | input | VAL_W | Value of the base register write |
| id_wr | input | 1 | Legacy ID write request |
| id_wr_val | input | 8 | Value of the legacy ID write |
| base_q | output | VAL_W | Current base/mode register contents |
| mode_o | output | 2 | Current mode: 0 off, 1 legacy, 2 extended |
| legacy_id | output | 8 | Software-visible legacy ID |
| ext_logical_id | output | 32 | Logical ID derived on entry to extended mode |
| wr_err | output | 1 | One-cycle pulse for a rejected write |
| sv_enable_clr | output | 1 | One-cycle strobe to clear the spurious vector enable |

## Verification
The bound checker enforces several rules on every cycle. The mode never takes the unused code 3 and never jumps from off straight to extended or from extended back to legacy. A rejected write freezes the register, and the register changes only after a request. The error and disable strobes never coincide, and the disable strobe only appears in off mode. Entry into extended mode carries the correctly formed logical ID. The bench's scenarios are needed for the rest: which requests are refused for which reason, the exact base field and preserved boot flag, the legacy ID restore on every kind of base write, and the precedence between a same-cycle ID write and a base write.

// File: rtl/cmg_pkg.sv
package cmg_pkg;

    localparam int EN_POS   = 11;
    localparam int EXT_POS  = 10;
    localparam int BSP_POS  = 8;
    localparam int BASE_LSB = 12;
    localparam int BASE_MSB = 31;
    localparam int BASE_W   = BASE_MSB - BASE_LSB + 1;
    localparam int LID_W    = 32;
    localparam int LID_HALF = LID_W / 2;

    typedef enum logic [1:0] {
        MODE_OFF    = 2'd0,
        MODE_LEGACY = 2'd1,
        MODE_EXT    = 2'd2
    } mode_e;

    typedef enum logic [2:0] {
        REJ_NONE,
        REJ_NO_CAP,
        REJ_BAD_STATE,
        REJ_SKIP_LEGACY,
        REJ_FALL_BACK
    } reject_e;

    typedef struct packed {
        logic              en;
        logic              ext;
        logic [BASE_W-1:0] base;
    } wr_fields_t;

    function automatic mode_e mode_from_bits(input logic en, input logic ext);
        if (!en)
            return MODE_OFF;
        else if (ext)
            return MODE_EXT;
        else
            return MODE_LEGACY;
    endfunction

endpackage

// File: rtl/cmg_transition_check.sv
module cmg_transition_check
    import cmg_pkg::*;
(
    input  mode_e      cur_mode,
    input  wr_fields_t req,
    input  logic       ext_ok,
    output logic       accept,
    output mode_e      next_mode,
    output logic       enter_ext,
    output logic       going_off
);
    reject_e why;

    always_comb begin
        why = REJ_NONE;
        if (req.ext && !ext_ok)
            why = REJ_NO_CAP;
        else if (req.ext && !req.en)
            why = REJ_BAD_STATE;
        else if (cur_mode == MODE_OFF && req.en && req.ext)
            why = REJ_SKIP_LEGACY;
        else if (cur_mode == MODE_EXT && req.en && !req.ext)
            why = REJ_FALL_BACK;
    end

    assign accept    = (why == REJ_NONE);
    assign next_mode = mode_from_bits(req.en, req.ext);
    assign enter_ext = accept && (next_mode == MODE_EXT) && (cur_mode != MODE_EXT);
    assign going_off = accept && !req.en;

endmodule

// File: rtl/cmg_logid_gen.sv
module cmg_logid_gen
    import cmg_pkg::*;
#(
    parameter int ID_W = 32
) (
    input  logic [ID_W-1:0]  init_id,
    output logic [LID_W-1:0] logical_id
);
    localparam int SEL_W = $clog2(LID_HALF);

    logic [ID_W-1:0]     shifted;
    logic [SEL_W-1:0]    sel;
    logic [LID_HALF-1:0] member;
    logic                unused_hi;

    assign shifted   = init_id >> SEL_W;
    assign sel       = init_id[SEL_W-1:0];
    assign unused_hi = ^shifted[ID_W-1:LID_HALF];

    for (genvar g = 0; g < LID_HALF; g++) begin : g_member
        assign member[g] = (sel == SEL_W'(g));
    end

    assign logical_id = {shifted[LID_HALF-1:0], member};

endmodule

// File: rtl/cmg_mode_guard.sv
module cmg_mode_guard
    import cmg_pkg::*;
#(
    parameter int                ID_W     = 32,
    parameter int                VAL_W    = 64,
    parameter logic [BASE_W-1:0] RST_BASE = 20'hFEE00,
    parameter logic              RST_BSP  = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ID_W-1:0]   init_id,
    input  logic              ext_supported,
    input  logic              wr_req,
    input  logic [VAL_W-1:0]  wr_val,
    input  logic              id_wr,
    input  logic [7:0]        id_wr_val,
    output logic [VAL_W-1:0]  base_q,
    output logic [1:0]        mode_o,
    output logic [7:0]        legacy_id,
    output logic [LID_W-1:0]  ext_logical_id,
    output logic              wr_err,
    output logic              sv_enable_clr
);
    wr_fields_t        req;
    mode_e             mode_q;
    mode_e             mode_nx;
    logic [BASE_W-1:0] base_fld;
    logic [7:0]        lid_q;
    logic [LID_W-1:0]  xlid_q;
    logic [LID_W-1:0]  xlid_calc;
    logic              err_q;
    logic              clr_q;
    logic              ok;
    logic              to_ext;
    logic              to_off;
    logic              unused_val;

    assign req.en   = wr_val[EN_POS];
    assign req.ext  = wr_val[EXT_POS];
    assign req.base = wr_val[BASE_MSB:BASE_LSB];
    assign unused_val = ^{wr_val[VAL_W-1:BASE_MSB+1], wr_val[9:0]};

    cmg_transition_check u_check (
        .cur_mode  (mode_q),
        .req       (req),
        .ext_ok    (ext_supported),
        .accept    (ok),
        .next_mode (mode_nx),
        .enter_ext (to_ext),
        .going_off (to_off)
    );

    cmg_logid_gen #(.ID_W(ID_W)) u_logid (
        .init_id    (init_id),
        .logical_id (xlid_calc)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q   <= MODE_LEGACY;
            base_fld <= RST_BASE;
            lid_q    <= init_id[7:0];
            xlid_q   <= '0;
            err_q    <= 1'b0;
            clr_q    <= 1'b0;
        end else begin
            err_q <= wr_req && !ok;
            clr_q <= wr_req && to_off;
            if (wr_req) begin
                lid_q <= init_id[7:0];
                if (ok) begin
                    mode_q   <= mode_nx;
                    base_fld <= req.base;
                end
                if (to_ext)
                    xlid_q <= xlid_calc;
            end else if (id_wr && mode_q != MODE_EXT) begin
                lid_q <= id_wr_val;
            end
        end
    end

    always_comb begin
        base_q                    = '0;
        base_q[BASE_MSB:BASE_LSB] = base_fld;
        base_q[EN_POS]            = (mode_q != MODE_OFF);
        base_q[EXT_POS]           = (mode_q == MODE_EXT);
        base_q[BSP_POS]           = RST_BSP;
    end

    assign mode_o         = mode_q;
    assign legacy_id      = lid_q;
    assign ext_logical_id = xlid_q;
    assign wr_err         = err_q;
    assign sv_enable_clr  = clr_q;

endmodule

// File: rtl/cmg_mode_guard_chk.sv
module cmg_mode_guard_chk #(
    parameter int ID_W  = 32,
    parameter int VAL_W = 64
) (
    input logic             clk,
    input logic             rst,
    input logic [ID_W-1:0]  init_id,
    input logic             wr_req,
    input logic [VAL_W-1:0] base_q,
    input logic [1:0]       mode_o,
    input logic [31:0]      ext_logical_id,
    input logic             wr_err,
    input logic             sv_enable_clr
);
    logic [ID_W-1:0] id_shift;
    assign id_shift = init_id >> 4;

    // R8: only the three legal mode codes
    assert_legal_mode_R8: assert property (@(posedge clk) disable iff (rst)
        mode_o != 2'd3);

    assert_no_skip_legacy_R4: assert property (@(posedge clk) disable iff (rst)
        (mode_o == 2'd0) |=> (mode_o != 2'd2));

    assert_no_fall_back_R5: assert property (@(posedge clk) disable iff (rst)
        (mode_o == 2'd2) |=> (mode_o != 2'd1));

    assert_reject_freezes_R6: assert property (@(posedge clk) disable iff (rst)
        wr_err |-> (base_q == $past(base_q) && mode_o == $past(mode_o)));

    assert_change_needs_write_R7: assert property (@(posedge clk) disable iff (rst)
        (base_q != $past(base_q)) |-> $past(wr_req));

    assert_strobes_exclusive_R6: assert property (@(posedge clk) disable iff (rst)
        !(wr_err && sv_enable_clr));

    assert_clear_only_off_R8: assert property (@(posedge clk) disable iff (rst)
        sv_enable_clr |-> (mode_o == 2'd0));

    assert_logid_on_entry_R9: assert property (@(posedge clk) disable iff (rst)
        (mode_o == 2'd2 && $past(mode_o) != 2'd2) |->
            (ext_logical_id[31:16] == id_shift[15:0] &&
             ext_logical_id[init_id[3:0]] &&
             $countones(ext_logical_id[15:0]) == 1));

endmodule

bind cmg_mode_guard cmg_mode_guard_chk #(.ID_W(ID_W), .VAL_W(VAL_W)) u_chk (
    .clk            (clk),
    .rst            (rst),
    .init_id        (init_id),
    .wr_req         (wr_req),
    .base_q         (base_q),
    .mode_o         (mode_o),
    .ext_logical_id (ext_logical_id),
    .wr_err         (wr_err),
    .sv_enable_clr  (sv_enable_clr)
);

// File: tb/cmg_mode_guard_tb.sv
module cmg_mode_guard_tb;

    logic        clk = 1'b0;
    logic        rst;
    logic [31:0] init_id;
    logic        ext_supported;
    logic        wr_req;
    logic [63:0] wr_val;
    logic        id_wr;
    logic [7:0]  id_wr_val;
    logic [63:0] base_q;
    logic [1:0]  mode_o;
    logic [7:0]  legacy_id;
    logic [31:0] ext_logical_id;
    logic        wr_err;
    logic        sv_enable_clr;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #10 clk = ~clk;

    cmg_mode_guard u_dut (
        .clk(clk), .rst(rst), .init_id(init_id), .ext_supported(ext_supported),
        .wr_req(wr_req), .wr_val(wr_val), .id_wr(id_wr), .id_wr_val(id_wr_val),
        .base_q(base_q), .mode_o(mode_o), .legacy_id(legacy_id),
        .ext_logical_id(ext_logical_id), .wr_err(wr_err), .sv_enable_clr(sv_enable_clr)
    );

    // {cap, exp_err, exp_mode[1:0], value[31:0]}
    localparam int NV = 13;
    localparam logic [35:0] VEC [NV] = '{
        {1'b0, 1'b1, 2'd1, 32'hFEE00C00}, // R2 no capability
        {1'b1, 1'b1, 2'd1, 32'h12345400}, // R3 extended without enable
        {1'b1, 1'b0, 2'd1, 32'hABCDEAF0}, // R7 junk bits ignored
        {1'b1, 1'b0, 2'd0, 32'h11111000}, // R8 turn off
        {1'b1, 1'b1, 2'd0, 32'h22222C00}, // R4 skip legacy
        {1'b1, 1'b1, 2'd0, 32'h33333400}, // R3
        {1'b1, 1'b0, 2'd0, 32'h44444000}, // R8 stay off
        {1'b1, 1'b0, 2'd1, 32'h55555800}, // R8 back to legacy
        {1'b1, 1'b0, 2'd2, 32'h66666C00}, // R9 enter extended
        {1'b1, 1'b1, 2'd2, 32'h77777800}, // R5 fall back
        {1'b1, 1'b0, 2'd2, 32'h88888C00}, // R7 stay extended
        {1'b1, 1'b0, 2'd0, 32'h99999000}, // R8
        {1'b1, 1'b0, 2'd1, 32'hAAAAA800}  // R8
    };

    task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [63:0] mk_base(input logic [19:0] b, input logic [1:0] m);
        logic [63:0] r = '0;
        r[31:12] = b;
        r[11]    = (m != 2'd0);
        r[10]    = (m == 2'd2);
        r[8]     = 1'b1;
        return r;
    endfunction

    function automatic logic [31:0] mk_lid(input logic [31:0] id);
        logic [31:0] r = '0;
        r[31:16] = id[19:4];
        r[id[3:0]] = 1'b1;
        return r;
    endfunction

    task automatic base_write(input logic [31:0] v, input logic cap);
        @(negedge clk);
        ext_supported = cap;
        wr_val  = {32'hDEAD0000, v};
        wr_req  = 1'b1;
        @(negedge clk);
        wr_req  = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [19:0] eb;
        logic [1:0]  em;
        rst = 1'b1; init_id = 32'h00000135; ext_supported = 1'b1;
        wr_req = 1'b0; wr_val = '0; id_wr = 1'b0; id_wr_val = '0;
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;

        // R1 reset state
        check(mode_o == 2'd1, "R1 mode", 64'(mode_o), 64'd1);
        check(base_q == mk_base(20'hFEE00, 2'd1), "R1 base", base_q, mk_base(20'hFEE00, 2'd1));
        check(legacy_id == 8'h35, "R1 legacy_id", 64'(legacy_id), 64'h35);
        check(ext_logical_id == 32'd0 && !wr_err && !sv_enable_clr, "R1 outputs",
              {ext_logical_id, 30'd0, wr_err, sv_enable_clr}, 64'd0);

        eb = 20'hFEE00; em = 2'd1;
        for (int i = 0; i < NV; i++) begin
            logic        cap, xerr;
            logic [1:0]  xm;
            logic [31:0] v;
            logic        was_ext;
            {cap, xerr, xm, v} = VEC[i];
            was_ext = (em == 2'd2);
            if (!xerr) begin eb = v[31:12]; em = xm; end
            base_write(v, cap);
            check(wr_err == xerr, xerr ? "R6 err pulse (R2/R3/R4/R5)" : "R7 no err", 64'(wr_err), 64'(xerr));
            check(mode_o == em, "R8 mode", 64'(mode_o), 64'(em));
            check(base_q == mk_base(eb, em), xerr ? "R6 base kept" : "R7 base loaded", base_q, mk_base(eb, em));
            check(sv_enable_clr == (!xerr && !v[11]), "R8 enable clear strobe",
                  64'(sv_enable_clr), 64'(!xerr && !v[11]));
            if (!xerr && xm == 2'd2 && !was_ext)
                check(ext_logical_id == mk_lid(init_id), "R9 logical id", 64'(ext_logical_id), 64'(mk_lid(init_id)));
            @(negedge clk);
            check(!wr_err && !sv_enable_clr, "R6 one-cycle pulses", {62'd0, wr_err, sv_enable_clr}, 64'd0);
        end

        // R11 legacy id write in legacy mode
        @(negedge clk); id_wr = 1'b1; id_wr_val = 8'hA7;
        @(negedge clk); id_wr = 1'b0;
        check(legacy_id == 8'hA7, "R11 id write", 64'(legacy_id), 64'hA7);
        // R10 rejected base write still restores id
        base_write(32'h12345400, 1'b1);
        check(wr_err && legacy_id == 8'h35, "R10 restore on reject", 64'(legacy_id), 64'h35);
        // R11 same-cycle: base write wins
        @(negedge clk); id_wr = 1'b1; id_wr_val = 8'h5C;
        wr_val = {32'd0, 32'hAAAAA800}; wr_req = 1'b1;
        @(negedge clk); id_wr = 1'b0; wr_req = 1'b0;
        check(legacy_id == 8'h35, "R11 base write wins", 64'(legacy_id), 64'h35);

        // R9 with a different initial id
        init_id = 32'h0001234F;
        base_write(32'hBBBBBC00, 1'b1);
        check(mode_o == 2'd2 && ext_logical_id == 32'h12348000, "R9 logical id 2",
              64'(ext_logical_id), 64'h12348000);
        check(legacy_id == 8'h4F, "R10 restore new id", 64'(legacy_id), 64'h4F);
        // R11 id write ignored in extended mode
        @(negedge clk); id_wr = 1'b1; id_wr_val = 8'h99;
        @(negedge clk); id_wr = 1'b0;
        check(legacy_id == 8'h4F, "R11 ignored in extended", 64'(legacy_id), 64'h4F);
        // R2 extended write without capability while extended
        base_write(32'hCCCCCC00, 1'b0);
        check(wr_err && base_q == mk_base(20'hBBBBB, 2'd2), "R2 reject keeps base",
              base_q, mk_base(20'hBBBBB, 2'd2));

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule